// File: doc/BRIEF.md
# Synchronous Burst SRAM Control Front-End

This block models the control side of a synchronous burst static RAM with a small storage array behind it. On every rising clock edge it looks at three chip enables, two address strobes, a burst-advance input, the write-enable group and a sleep input. From these it decides whether the cycle deselects the part, opens a burst at the address on the address pins, steps the running burst to its next address, or holds the burst at its current address.

The processor-side strobe always opens a read, and it is only honoured when the primary enable is active. The controller-side strobe opens a read or a write, depending on the write-enable group. The burst steps through the two low address bits in linear order, wrapping within a group of four, while the upper bits stay as they were when the burst opened. Reads are flow-through: after the edge, the word at the current address drives the bidirectional data bus at once, gated by an output enable that is not clocked. Write data is taken from the bus at the edge that commits the write.

A sleep input overrides everything. It releases the bus at once and blocks all accesses. After sleep is lowered, the block ignores a fixed number of further edges before it accepts an access again.

Top module: `syncburst_sram`

## Requirements
- R1: While reset is asserted, and on the edges after it until a burst is opened, the data bus is not driven, even with output enable low.
- R2: While the sleep input is high, the data bus is released at once, without waiting for a clock edge. An access attempted on an edge where sleep is high changes no stored data.
- R3: The first two edges with sleep low, after an edge with sleep high, accept no access. Reads and writes on those edges have no effect, and an access on the third edge is carried out.
- R4: An edge is a deselect when sleep is low and either of these holds: the controller strobe is low while the chip is not selected, or the processor strobe and the primary enable are both low while the chip is not selected. The chip is selected when the primary enable is low, the second enable is high and the third enable is low. A deselect releases the bus and ends the burst, so later hold or step edges do not drive the bus.
- R5: With the chip selected and the processor strobe low, the edge opens a read at the external address, whatever the write-enable inputs show. Stored data does not change.
- R6: When the primary enable is high, the processor strobe is ignored. With the controller strobe high, the edge continues the running burst and does not load the address pins.
- R7: With the chip selected, the processor strobe high and the controller strobe low, the edge opens a burst at the external address. The burst is a write when the internal write signal is low, and a read otherwise.
- R8: Byte lane b (bits 8b+7..8b) is written when global write is low, or when the byte-write enable and byte enable b are both low. The internal write signal is low when any lane is written. With byte-write enable low and all byte enables high, or with byte-write enable high and global write high, the cycle is a read.
- R9: On a continue edge with advance low, the address goes to the next one: the two low bits count up by one modulo 4, and the upper bits are kept. Reads and writes both follow the write signal.
- R10: On a continue edge with advance high, the burst stays at its current address, and the address pins are ignored.
- R11: During a read phase the bus is driven only while output enable is low, and it follows output enable without a clock. After a write edge the bus is not driven, even with output enable low.
- R12: Read data for the address chosen at an edge appears on the bus in the same cycle, right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| sleepIn | input | 1 | Sleep request, active high, overrides all other inputs |
| ceMainN | input | 1 | Primary chip enable, active low; gates the processor strobe |
| ceHi | input | 1 | Second chip enable, active high |
| ceAltN | input | 1 | Third chip enable, active low |
| procStrbN | input | 1 | Processor address strobe, active low, always opens a read |
| ctrlStrbN | input | 1 | Controller address strobe, active low, opens a read or a write |
| advN | input | 1 | Burst advance on continue edges, active low; high holds |
| globalWrN | input | 1 | Global write, active low, writes all byte lanes |
| byteWrEnN | input | 1 | Byte-write enable, active low, qualifies the byte enables |
| byteEnN | input | DATA_W/8 | Per-lane byte enables, active low |
| oeN | input | 1 | Output enable, active low, not clocked |
| addr | input | ADDR_W | External word address |
| dq | inout | DATA_W | Bidirectional data bus |

## Verification
The burst wrap is tested by opening a read at address 6 and stepping it. A counter that carried into the upper bits would show address 8 instead of address 4. The processor strobe is asserted with the write group active and the bus left floating, so a design that let it write would show garbage where the stored word belongs. The bench raises the primary enable while the processor strobe is low, and a design that still loaded the address pins would jump to the wrong word. Reads and writes are attempted on the sleep edge and on both recovery edges: a short recovery count would drive the bus early, and a missed sleep gate would corrupt the stored word. Output enable is toggled with no clock edge, and it is also held low straight after a write edge. A clocked output enable, or one that is not masked during writes, would then drive stale or written data.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  // Per-edge decision handed from control to datapath
  typedef struct packed {
    logic accept;  // edge is allowed to act (not asleep, not recovering)
    logic load;    // open a burst at the external address
    logic step;    // continue burst at next address
    logic hold;    // continue burst at current address
    logic write;   // this edge commits a write
  } strb_t;

endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl #(
  parameter int LANES       = 4,
  parameter int WAKE_CYCLES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sleepIn,
  input  logic                ceMainN,
  input  logic                ceHi,
  input  logic                ceAltN,
  input  logic                procStrbN,
  input  logic                ctrlStrbN,
  input  logic                advN,
  input  logic                globalWrN,
  input  logic                byteWrEnN,
  input  logic [LANES-1:0]    byteEnN,
  output sbs_pkg::strb_t      strb,
  output logic [LANES-1:0]    byteMask,
  output logic                readPhase
);
  localparam int WCW = $clog2(WAKE_CYCLES + 1);

  logic           active;
  logic [WCW-1:0] wakeCnt;
  logic           selected;
  logic           wrLow;
  logic           cycleGo;

  // Lane write mask; any enabled lane makes the edge a write
  for (genvar b = 0; b < LANES; b++) begin : g_mask
    assign byteMask[b] = !globalWrN || (!byteWrEnN && !byteEnN[b]);
  end
  assign wrLow    = |byteMask;
  assign selected = !ceMainN && ceHi && !ceAltN;

  always_comb begin
    strb        = '0;
    strb.accept = !sleepIn && (wakeCnt == '0);
    if (strb.accept) begin
      if (!ceMainN && !procStrbN) begin
        // processor strobe: read only, deselect if not fully selected
        strb.load = selected;
      end else if (!ctrlStrbN) begin
        if (selected) begin
          strb.load  = 1'b1;
          strb.write = wrLow;
        end
      end else if (active) begin
        strb.step  = !advN;
        strb.hold  = advN;
        strb.write = wrLow;
      end
    end
  end

  assign cycleGo = strb.load || strb.step || strb.hold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      readPhase <= 1'b0;
      wakeCnt   <= '0;
    end else begin
      if (sleepIn)
        wakeCnt <= WCW'(WAKE_CYCLES);
      else if (wakeCnt != '0)
        wakeCnt <= wakeCnt - 1'b1;
      active    <= cycleGo;
      readPhase <= cycleGo && !strb.write;
    end
  end

endmodule

// File: rtl/sbs_datapath.sv
module sbs_datapath #(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32,
  parameter int BURST_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  sbs_pkg::strb_t      strb,
  input  logic [DATA_W/8-1:0] byteMask,
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LANES = DATA_W / 8;

  logic [ADDR_W-1:0]  curAddr;
  logic [ADDR_W-1:0]  tgtAddr;
  logic [BURST_W-1:0] nextLow;

  assign nextLow = curAddr[BURST_W-1:0] + BURST_W'(1);

  always_comb begin
    if (strb.load)
      tgtAddr = addrIn;
    else if (strb.step)
      tgtAddr = {curAddr[ADDR_W-1:BURST_W], nextLow};
    else
      tgtAddr = curAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      curAddr <= '0;
    else if (strb.load || strb.step)
      curAddr <= tgtAddr;
  end

  // One storage array per byte lane
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [7:0] lane [DEPTH];
    always_ff @(posedge clk) begin
      if (strb.write && byteMask[b])
        lane[tgtAddr] <= wrData[b*8 +: 8];
    end
    assign rdData[b*8 +: 8] = lane[curAddr];
  end

endmodule

// File: rtl/syncburst_sram.sv
module syncburst_sram #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 32,
  parameter int BURST_W     = 2,
  parameter int WAKE_CYCLES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sleepIn,
  input  logic                ceMainN,
  input  logic                ceHi,
  input  logic                ceAltN,
  input  logic                procStrbN,
  input  logic                ctrlStrbN,
  input  logic                advN,
  input  logic                globalWrN,
  input  logic                byteWrEnN,
  input  logic [DATA_W/8-1:0] byteEnN,
  input  logic                oeN,
  input  logic [ADDR_W-1:0]   addr,
  inout  wire  [DATA_W-1:0]   dq
);
  localparam int LANES = DATA_W / 8;

  sbs_pkg::strb_t    strb;
  logic [LANES-1:0]  byteMask;
  logic              readPhase;
  logic              busDrive;
  logic [DATA_W-1:0] rdData;

  sbs_ctrl #(.LANES(LANES), .WAKE_CYCLES(WAKE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sleepIn(sleepIn),
    .ceMainN(ceMainN), .ceHi(ceHi), .ceAltN(ceAltN),
    .procStrbN(procStrbN), .ctrlStrbN(ctrlStrbN), .advN(advN),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .byteEnN(byteEnN),
    .strb(strb), .byteMask(byteMask), .readPhase(readPhase)
  );

  sbs_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_W(BURST_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .byteMask(byteMask),
    .addrIn(addr), .wrData(dq), .rdData(rdData)
  );

  // Output enable and sleep act without a clock
  assign busDrive = readPhase && !oeN && !sleepIn;
  assign dq       = busDrive ? rdData : {DATA_W{1'bz}};

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker (
  input logic clk,
  input logic rstN,
  input logic sleepIn,
  input logic ceMainN,
  input logic procStrbN,
  input logic ctrlStrbN,
  input logic busDrive,
  input logic strbAccept,
  input logic strbWrite
);

  // R2: sleep keeps the bus released and blocks acceptance
  a_r2_sleep_quiet: assert property (@(posedge clk) disable iff (!rstN)
    sleepIn |-> (!busDrive && !strbAccept));

  // R3: first edge after sleep is lowered accepts nothing
  a_r3_wake_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!sleepIn && $past(sleepIn)) |-> !strbAccept);

  // R4: controller strobe with primary enable high deselects
  a_r4_deselect: assert property (@(posedge clk) disable iff (!rstN)
    (!sleepIn && !ctrlStrbN && ceMainN) |=> !busDrive);

  // R5: processor strobe never commits a write
  a_r5_proc_read: assert property (@(posedge clk) disable iff (!rstN)
    (!ceMainN && !procStrbN) |-> !strbWrite);

  // R11: bus stays released after a write edge
  a_r11_write_quiet: assert property (@(posedge clk) disable iff (!rstN)
    strbWrite |=> !busDrive);

endmodule

bind syncburst_sram sbs_checker u_chk (
  .clk(clk), .rstN(rstN), .sleepIn(sleepIn), .ceMainN(ceMainN),
  .procStrbN(procStrbN), .ctrlStrbN(ctrlStrbN), .busDrive(busDrive),
  .strbAccept(strb.accept), .strbWrite(strb.write)
);

// File: tb/syncburst_sram_test.sv
module syncburst_sram_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sleepIn, ceMainN, ceHi, ceAltN, procStrbN, ctrlStrbN, advN;
  logic        globalWrN, byteWrEnN, oeN;
  logic [3:0]  byteEnN;
  logic [5:0]  addr;
  logic [31:0] tbDq;
  logic        tbDrv;
  wire  [31:0] dq;
  logic [31:0] expMem [64];
  int          tests = 0;
  int          fails = 0;
  bit          done = 1'b0;

  assign dq = tbDrv ? tbDq : 32'bz;

  always #5 clk = ~clk;

  syncburst_sram uut (
    .clk(clk), .rstN(rstN), .sleepIn(sleepIn), .ceMainN(ceMainN), .ceHi(ceHi),
    .ceAltN(ceAltN), .procStrbN(procStrbN), .ctrlStrbN(ctrlStrbN), .advN(advN),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .byteEnN(byteEnN), .oeN(oeN),
    .addr(addr), .dq(dq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // Continue-hold inputs, bus released by bench, output enable high
  task automatic quiet();
    sleepIn = 0; ceMainN = 1; ceHi = 1; ceAltN = 0; procStrbN = 1;
    ctrlStrbN = 1; advN = 1; globalWrN = 1; byteWrEnN = 1; byteEnN = 4'hF;
    oeN = 1; addr = '0; tbDrv = 0; tbDq = '0;
  endtask

  task automatic writeCtrl(input logic [5:0] a, input logic [31:0] d);
    quiet();
    ceMainN = 0; ctrlStrbN = 0; globalWrN = 0; addr = a; tbDq = d; tbDrv = 1;
    tick();
    expMem[a] = d;
    quiet();
  endtask

  task automatic readCtrl(input logic [5:0] a, input string tag);
    quiet();
    ceMainN = 0; ctrlStrbN = 0; addr = a; oeN = 0;
    tick();
    chk(dq === expMem[a], tag, dq, expMem[a]);
    quiet();
    oeN = 0;
  endtask

  task automatic t_fill();  // R7
    for (int i = 0; i < 8; i++)
      writeCtrl(6'(i), {8'(8'h10 + i), 8'(8'h20 + i), 8'(8'h30 + i), 8'(8'h40 + i)});
    for (int i = 0; i < 8; i++)
      readCtrl(6'(i), "R7 controller strobe write then read");
  endtask

  task automatic t_proc_read();  // R5 R12 R11
    quiet();
    ceMainN = 0; procStrbN = 0; globalWrN = 0; byteWrEnN = 0; byteEnN = 4'h0;
    addr = 6'd5; oeN = 0;
    tick();
    chk(dq === expMem[5], "R5 R12 processor strobe reads same cycle", dq, expMem[5]);
    quiet();
    oeN = 0;
    #1 chk(dq === expMem[5], "R11 read holds with oe low", dq, expMem[5]);
    oeN = 1;
    #1 chk(dq !== expMem[5], "R11 oe high releases bus without clock", dq, ~expMem[5]);
    oeN = 0;
    #1 chk(dq === expMem[5], "R11 oe low drives again without clock", dq, expMem[5]);
    quiet();
  endtask

  task automatic t_burst();  // R9 R10 R6
    readCtrl(6'd6, "R9 burst opens at 6");
    advN = 0;
    tick(); chk(dq === expMem[7], "R9 step to 7", dq, expMem[7]);
    tick(); chk(dq === expMem[4], "R9 wrap to 4", dq, expMem[4]);
    tick(); chk(dq === expMem[5], "R9 step to 5", dq, expMem[5]);
    advN = 1; addr = 6'd0;
    tick(); chk(dq === expMem[5], "R10 suspend keeps 5", dq, expMem[5]);
    ceMainN = 1; procStrbN = 0; advN = 0; addr = 6'd1;
    tick(); chk(dq === expMem[6], "R6 processor strobe ignored, step to 6", dq, expMem[6]);
    quiet();
  endtask

  task automatic t_deselect();  // R4
    readCtrl(6'd3, "R4 setup read 3");
    ctrlStrbN = 0;
    tick(); chk(dq !== expMem[3], "R4 controller strobe deselect", dq, ~expMem[3]);
    ctrlStrbN = 1;
    tick(); chk(dq !== expMem[3], "R4 burst ended after deselect", dq, ~expMem[3]);
    readCtrl(6'd2, "R4 setup read 2");
    ceMainN = 0; procStrbN = 0; ceHi = 0; addr = 6'd2;
    tick(); chk(dq !== expMem[2], "R4 processor strobe deselect", dq, ~expMem[2]);
    quiet();
  endtask

  task automatic t_bytes();  // R8
    logic [31:0] d;
    d = 32'hCAFEBABE;
    quiet();
    ceMainN = 0; ctrlStrbN = 0; byteWrEnN = 0; byteEnN = 4'b1010;
    addr = 6'd3; tbDq = d; tbDrv = 1;
    tick();
    expMem[3] = (expMem[3] & 32'hFF00FF00) | (d & 32'h00FF00FF);
    quiet();
    ceMainN = 0; ctrlStrbN = 0; byteWrEnN = 0; byteEnN = 4'hF; addr = 6'd3; oeN = 0;
    tick(); chk(dq === expMem[3], "R8 lanes 0 2 written; no lane enabled reads", dq, expMem[3]);
    byteWrEnN = 1; byteEnN = 4'h0;
    tick(); chk(dq === expMem[3], "R8 byte enables without byte-write enable read", dq, expMem[3]);
    quiet();
  endtask

  task automatic t_cont_write();  // R9 R7
    writeCtrl(6'd0, 32'h0BADF00D);
    globalWrN = 0; advN = 0; tbDq = 32'h600DCAFE; tbDrv = 1;
    tick();
    expMem[1] = 32'h600DCAFE;
    quiet();
    readCtrl(6'd0, "R7 write burst first word");
    advN = 0;
    tick(); chk(dq === expMem[1], "R9 continue write landed at next address", dq, expMem[1]);
    quiet();
  endtask

  task automatic t_write_mask();  // R11
    writeCtrl(6'd4, 32'h5A5AC3C3);
    oeN = 0;
    #1 chk(dq !== 32'h5A5AC3C3, "R11 oe masked after write edge", dq, ~32'h5A5AC3C3);
    tick(); chk(dq === expMem[4], "R11 suspend read shows written word", dq, expMem[4]);
    quiet();
  endtask

  task automatic t_sleep();  // R2 R3
    readCtrl(6'd2, "R2 setup read 2");
    sleepIn = 1;
    #1 chk(dq !== expMem[2], "R2 sleep releases bus at once", dq, ~expMem[2]);
    ceMainN = 0; ctrlStrbN = 0; globalWrN = 0; addr = 6'd2; oeN = 1;
    tbDq = 32'hDEAD0001; tbDrv = 1;
    tick();
    quiet();
    ceMainN = 0; procStrbN = 0; addr = 6'd2; oeN = 0;
    tick(); chk(dq !== expMem[2], "R3 first wake edge ignored", dq, ~expMem[2]);
    quiet();
    ceMainN = 0; ctrlStrbN = 0; globalWrN = 0; addr = 6'd2;
    tbDq = 32'hDEAD0002; tbDrv = 1;
    tick();
    quiet();
    ceMainN = 0; procStrbN = 0; addr = 6'd2; oeN = 0;
    tick(); chk(dq === expMem[2], "R2 R3 third edge accepted, no write landed", dq, expMem[2]);
    quiet();
  endtask

  task automatic t_reset();  // R1
    readCtrl(6'd7, "R1 setup read 7");
    rstN = 0;
    #1 chk(dq !== expMem[7], "R1 reset releases bus", dq, ~expMem[7]);
    tick();
    rstN = 1;
    tick(); chk(dq !== expMem[7], "R1 no burst after reset", dq, ~expMem[7]);
    quiet();
  endtask

  initial begin
    quiet();
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    tick();
    t_fill();
    t_proc_read();
    t_burst();
    t_deselect();
    t_bytes();
    t_cont_write();
    t_write_mask();
    t_sleep();
    t_reset();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule